// File: doc/BRIEF.md
# Two-Adapter Interrupt Level Merger

This block sits between the peripherals of two I/O bus adapters and a CPU priority-interrupt system. Device requests are held as a vector of pending bits. A static mask per adapter splits those bits into a high group, which gathers device bus levels 7 and 6, and a low group, which gathers levels 5 and 4. Each adapter owns a status register. Software programs two CPU level fields in it, one for the high group and one for the low group. The block raises a one-hot CPU level bit for every group that has work and ORs the results from both adapters into one level mask.

When the CPU acknowledges a level, the block finds the request that wins at that level and returns that request's vector and the identifier of its adapter. The pending bit is dropped on the next clock edge. A configuration port loads the vector for each request bit.

The status register can be read and written. A read folds live "group pending" flags into the register. A write can either store the level fields or, with the init bit set, reset the devices behind that adapter.

Top module: `irq_level_merge`

## Requirements
- R1: Request bit i belongs to adapter a's high group when bit i of that adapter's HI_MASKS slice is set, and to its low group when bit i of its LO_MASKS slice is set. With the defaults, adapter 0 has high bits 4..7 and low bits 0..3, and adapter 1 has high bits 16..19 and low bits 20..23.
- R2: Bit L of `lvl_req` is 1 exactly when some adapter holds L in a group's level field and that group has a pending request. The low level field is status bits 2:0 and the high level field is bits 5:3. A field value of 0 raises no bit.
- R3: For an acknowledge at level L, adapter 0 is searched before adapter 1. Within an adapter the high group is tried before the low group. A group qualifies only when its field equals L and it has a pending request. An acknowledge at level 0 never matches.
- R4: Within the qualifying group, the lowest-numbered pending bit wins. Its vector, as loaded through the cfg port, is returned in the same cycle with `ack_hit` = 1, and the bit is cleared at the next edge. With no match, `ack_hit`, `ack_vec` and `ack_adp` are all 0.
- R5: The adapter identifier returned on a hit is 2 × index + 1, which gives 1 for adapter 0 and 3 for adapter 1.
- R6: A status read returns the stored register with the live flags ORed in: bit 9 is "high group pending" and bit 8 is "low group pending". Bit 7 always reads as 0. The value read is written back into the register, so a flag stays set after its requests are gone, until the next write.
- R7: A write with bit 7 clear stores bits 6:0. The flags in bits 9:8 are then recomputed from the live requests.
- R8: A write with bit 7 (init) set does four things: it pulses `dev_init` for that adapter for one cycle after the write edge, it drops all pending bits of that adapter's groups, it keeps only bit 6 (transfer-off) of the written value, and it leaves both flags at 0. The other adapter is untouched.
- R9: A request set in the same cycle as the acknowledge that clears the same bit leaves the bit pending.
- R10: Synchronous reset clears both status registers and all pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NREQ | One-cycle pulses that set pending request bits |
| cfg_we | input | 1 | Vector table write strobe |
| cfg_idx | input | clog2(NREQ) | Request bit whose vector is written |
| cfg_vec | input | VEC_W | Vector value to store |
| csr_rd | input | 1 | Status register read strobe |
| csr_wr | input | 1 | Status register write strobe |
| csr_sel | input | 1 (N_ADP=2) | Adapter index of the status access |
| csr_wdata | input | 10 | Status write data |
| csr_rdata | output | 10 | Status read data, valid in the cycle of the read strobe |
| dev_init | output | N_ADP | One-cycle device reset pulse per adapter |
| lvl_req | output | 8 | Combined CPU level request mask, bit L = level L |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_vec | output | VEC_W | Vector of the winning request |
| ack_adp | output | clog2(2·N_ADP) | Adapter identifier of the winner |
| ack_hit | output | 1 | A request matched the acknowledge |

## Verification
The bench uses the default parameters: two adapters, 32 request bits and 16-bit vectors. Because the default masks put the high group of adapter 0 above its low group in bit order, choosing the high group first gives a different winner from choosing the lowest bit overall, so that ordering can be observed. With two adapters, both can be set to one level so that the adapter search order decides the winner. Identifiers 1 and 3, and the level-0 disable, can also be seen at the ports.

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int N_ADP = 2,
  parameter int NREQ  = 32,
  parameter int VEC_W = 16,
  parameter logic [N_ADP*NREQ-1:0] HI_MASKS = {32'h000F0000, 32'h000000F0},
  parameter logic [N_ADP*NREQ-1:0] LO_MASKS = {32'h00F00000, 32'h0000000F}
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NREQ-1:0]                        req_set,
  input  logic                                   cfg_we,
  input  logic [$clog2(NREQ)-1:0]                cfg_idx,
  input  logic [VEC_W-1:0]                       cfg_vec,
  input  logic                                   csr_rd,
  input  logic                                   csr_wr,
  input  logic [((N_ADP > 1) ? $clog2(N_ADP) : 1)-1:0] csr_sel,
  input  logic [9:0]                             csr_wdata,
  output logic [9:0]                             csr_rdata,
  output logic [N_ADP-1:0]                       dev_init,
  output logic [7:0]                             lvl_req,
  input  logic                                   ack_valid,
  input  logic [2:0]                             ack_lvl,
  output logic [VEC_W-1:0]                       ack_vec,
  output logic [$clog2(2*N_ADP)-1:0]             ack_adp,
  output logic                                   ack_hit
);
  localparam int LVL_W  = 3;
  localparam int CSR_W  = 2*LVL_W + 4;
  localparam int IDX_W  = $clog2(NREQ);
  localparam int SEL_W  = (N_ADP > 1) ? $clog2(N_ADP) : 1;
  localparam int ADP_W  = $clog2(2*N_ADP);
  localparam int B_XOFF = 2*LVL_W;
  localparam int B_INIT = B_XOFF + 1;
  localparam int B_LOP  = B_XOFF + 2;
  localparam int B_HIP  = B_XOFF + 3;
  localparam logic [CSR_W-1:0] WR_MASK  = CSR_W'((1 << (B_XOFF+1)) - 1);
  localparam logic [CSR_W-1:0] XOFF_BIT = CSR_W'(1) << B_XOFF;
  localparam logic [CSR_W-1:0] RDZ_BIT  = CSR_W'(1) << B_INIT;
  localparam logic [CSR_W-1:0] LOP_BIT  = CSR_W'(1) << B_LOP;
  localparam logic [CSR_W-1:0] HIP_BIT  = CSR_W'(1) << B_HIP;

  logic [NREQ-1:0]  pend;
  logic [CSR_W-1:0] stat    [N_ADP];
  logic [CSR_W-1:0] flg     [N_ADP];
  logic [CSR_W-1:0] rd_view [N_ADP];
  logic [LVL_W-1:0] hi_lvl  [N_ADP];
  logic [LVL_W-1:0] lo_lvl  [N_ADP];
  logic [VEC_W-1:0] vtab    [NREQ];
  logic [N_ADP-1:0] hi_any, lo_any, wr_hit, rd_hit;

  for (genvar a = 0; a < N_ADP; a++) begin : g_adp
    assign hi_any[a]  = |(pend & HI_MASKS[a*NREQ +: NREQ]);
    assign lo_any[a]  = |(pend & LO_MASKS[a*NREQ +: NREQ]);
    assign hi_lvl[a]  = stat[a][2*LVL_W-1:LVL_W];
    assign lo_lvl[a]  = stat[a][LVL_W-1:0];
    assign flg[a]     = (hi_any[a] ? HIP_BIT : '0) | (lo_any[a] ? LOP_BIT : '0);
    assign rd_view[a] = (stat[a] | flg[a]) & ~RDZ_BIT;
    assign wr_hit[a]  = csr_wr && (csr_sel == SEL_W'(a));
    assign rd_hit[a]  = csr_rd && (csr_sel == SEL_W'(a));
  end

  assign csr_rdata = rd_view[csr_sel];

  always_comb begin
    lvl_req = '0;
    for (int a = 0; a < N_ADP; a++) begin
      if (hi_any[a] && hi_lvl[a] != '0) lvl_req[hi_lvl[a]] = 1'b1;
      if (lo_any[a] && lo_lvl[a] != '0) lvl_req[lo_lvl[a]] = 1'b1;
    end
  end

  logic             found;
  logic [NREQ-1:0]  sel_word;
  logic [ADP_W-1:0] win_adp;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    found    = 1'b0;
    sel_word = '0;
    win_adp  = '0;
    for (int a = 0; a < N_ADP; a++) begin
      if (!found && ack_lvl != '0) begin
        if (hi_lvl[a] == ack_lvl && hi_any[a]) begin
          found    = 1'b1;
          sel_word = pend & HI_MASKS[a*NREQ +: NREQ];
          win_adp  = ADP_W'(2*a + 1);
        end else if (lo_lvl[a] == ack_lvl && lo_any[a]) begin
          found    = 1'b1;
          sel_word = pend & LO_MASKS[a*NREQ +: NREQ];
          win_adp  = ADP_W'(2*a + 1);
        end
      end
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = NREQ-1; i >= 0; i--)
      if (sel_word[i]) win_idx = IDX_W'(i);
  end

  assign ack_hit = ack_valid && found;
  assign ack_vec = ack_hit ? vtab[win_idx] : '0;
  assign ack_adp = ack_hit ? win_adp : '0;

  logic [NREQ-1:0] clr_mask, init_clr;
  assign clr_mask = ack_hit ? (NREQ'(1) << win_idx) : '0;

  always_comb begin
    init_clr = '0;
    for (int a = 0; a < N_ADP; a++)
      if (wr_hit[a] && csr_wdata[B_INIT])
        init_clr = init_clr | HI_MASKS[a*NREQ +: NREQ] | LO_MASKS[a*NREQ +: NREQ];
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask & ~init_clr) | req_set;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) vtab[cfg_idx] <= cfg_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < N_ADP; a++) stat[a] <= '0;
      dev_init <= '0;
    end else begin
      for (int a = 0; a < N_ADP; a++) begin
        dev_init[a] <= wr_hit[a] && csr_wdata[B_INIT];
        if (wr_hit[a])
          stat[a] <= csr_wdata[B_INIT] ? (csr_wdata & XOFF_BIT)
                                       : ((csr_wdata & WR_MASK) | flg[a]);
        else if (rd_hit[a])
          stat[a] <= rd_view[a];
      end
    end
  end
endmodule

module irq_level_merge_chk #(
  parameter int N_ADP = 2,
  parameter int NREQ  = 32,
  parameter int VEC_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NREQ-1:0]            req_set,
  input logic [NREQ-1:0]            pend,
  input logic                       csr_wr,
  input logic [N_ADP-1:0]           dev_init,
  input logic [7:0]                 lvl_req,
  input logic                       ack_valid,
  input logic                       ack_hit,
  input logic [$clog2(2*N_ADP)-1:0] ack_adp,
  input logic [VEC_W-1:0]           ack_vec
);
  AST_ADP_ODD: assert property (@(posedge clk) disable iff (rst) ack_hit |-> ack_adp[0]); // R5
  AST_ACK_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && req_set == '0 && !csr_wr) |=> $countones(pend) == $past($countones(pend)) - 1); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> (pend & $past(req_set)) == $past(req_set)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> (lvl_req == '0 && !ack_hit)); // R2
  AST_HIT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    ack_hit |-> (ack_valid && pend != '0)); // R3
  AST_INIT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(dev_init)); // R8
endmodule

bind irq_level_merge irq_level_merge_chk #(.N_ADP(N_ADP), .NREQ(NREQ), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .req_set(req_set), .pend(pend), .csr_wr(csr_wr),
  .dev_init(dev_init), .lvl_req(lvl_req), .ack_valid(ack_valid), .ack_hit(ack_hit),
  .ack_adp(ack_adp), .ack_vec(ack_vec));

// File: tb/irq_level_merge_bench.sv
module irq_level_merge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] req_set = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [15:0] cfg_vec = '0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [0:0]  csr_sel = '0;
  logic [9:0]  csr_wdata = '0;
  logic [9:0]  csr_rdata;
  logic [1:0]  dev_init;
  logic [7:0]  lvl_req;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_lvl = '0;
  logic [15:0] ack_vec;
  logic [1:0]  ack_adp;
  logic        ack_hit;
  logic        snap = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_merge u_irq_level_merge (
    .clk(clk), .rst(rst), .req_set(req_set), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_vec(cfg_vec), .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dev_init(dev_init),
    .lvl_req(lvl_req), .ack_valid(ack_valid), .ack_lvl(ack_lvl), .ack_vec(ack_vec),
    .ack_adp(ack_adp), .ack_hit(ack_hit));

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int compared = 0, mismatched = 0;

  function automatic logic [15:0] vec_of(int i);
    return 16'h0100 + 16'(4*i);
  endfunction

  always @(negedge clk) begin
    logic [31:0] act, exp;
    string tag;
    if (!rst && (ack_valid || csr_rd || snap)) begin
      if (ack_valid)   act = {13'b0, ack_hit, ack_adp, ack_vec};
      else if (csr_rd) act = {22'b0, csr_rdata};
      else             act = {22'b0, dev_init, lvl_req};
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL unexpected result: actual %h expected none", act);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        if (act !== exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic csr_write(int sel, logic [9:0] d);
    csr_sel = 1'(sel); csr_wdata = d; csr_wr = 1'b1; step(); csr_wr = 1'b0;
  endtask

  task automatic csr_read(int sel, logic [9:0] e, string t);
    push({22'b0, e}, t);
    csr_sel = 1'(sel); csr_rd = 1'b1; step(); csr_rd = 1'b0;
  endtask

  task automatic raise(logic [31:0] m);
    req_set = m; step(); req_set = '0;
  endtask

  task automatic look(logic [1:0] ei, logic [7:0] el, string t);
    push({22'b0, ei, el}, t);
    snap = 1'b1; step(); snap = 1'b0;
  endtask

  task automatic ack(int lvl, bit hit, int adp, int idx, string t, logic [31:0] extra = '0);
    push(hit ? {13'b0, 1'b1, 2'(adp), vec_of(idx)} : 32'h0, t);
    ack_lvl = 3'(lvl); ack_valid = 1'b1; req_set = extra;
    step();
    ack_valid = 1'b0; req_set = '0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      cfg_we = 1'b1; cfg_idx = 5'(i); cfg_vec = vec_of(i); step();
    end
    cfg_we = 1'b0;

    look(2'b00, 8'h00, "R10 no level after reset");
    csr_read(0, 10'h000, "R10 adapter 0 status cleared");
    csr_read(1, 10'h000, "R10 adapter 1 status cleared");

    csr_write(0, 10'h02B);
    csr_write(1, 10'h032);
    csr_read(0, 10'h02B, "R7 level fields stored");

    raise(32'h0000_0060);
    look(2'b00, 8'h20, "R1 R2 adapter 0 high group on level 5");
    csr_read(0, 10'h22B, "R6 high pending flag folded in");
    ack(5, 1, 1, 5, "R4 lowest bit wins");
    ack(5, 1, 1, 6, "R4 next bit after clear");
    ack(5, 0, 0, 0, "R4 no match gives zero");
    look(2'b00, 8'h00, "R2 level drops when empty");
    csr_read(0, 10'h22B, "R6 flag sticky after read");
    csr_write(0, 10'h02B);
    csr_read(0, 10'h02B, "R7 write recomputes flags");

    csr_write(0, 10'h02E);
    raise(32'h0001_0004);
    look(2'b00, 8'h40, "R2 two adapters share level 6");
    csr_read(1, 10'h232, "R6 adapter 1 high flag");
    csr_read(0, 10'h12E, "R6 adapter 0 low flag");
    ack(6, 1, 1, 2, "R3 adapter 0 searched first");
    ack(6, 1, 3, 16, "R5 adapter 1 identifier");

    csr_write(0, 10'h024);
    raise(32'h0000_0081);
    ack(4, 1, 1, 7, "R3 high group before low group");
    ack(4, 1, 1, 0, "R3 low group after empty high");
    raise(32'h0010_0000);
    ack(2, 1, 3, 20, "R1 adapter 1 low group on level 2");

    csr_write(1, 10'h000);
    raise(32'h0002_0000);
    look(2'b00, 8'h00, "R2 field zero raises nothing");
    ack(0, 0, 0, 0, "R3 level zero never matches");
    csr_write(1, 10'h038);
    look(2'b00, 8'h80, "R2 level 7 after field set");

    ack(7, 1, 3, 17, "R9 ack with same-cycle request", 32'h0002_0000);
    look(2'b00, 8'h80, "R9 request still pending");
    ack(7, 1, 3, 17, "R9 second ack of same bit");
    ack(7, 0, 0, 0, "R4 empty after second ack");

    raise(32'h0004_0008);
    look(2'b00, 8'h90, "R2 levels 4 and 7");
    csr_write(0, 10'h0FF);
    look(2'b01, 8'h80, "R8 init pulse and adapter 0 requests dropped");
    csr_read(0, 10'h040, "R8 only transfer-off bit kept");
    ack(7, 1, 3, 18, "R8 other adapter untouched");

    raise(32'h0008_0000);
    rst = 1'b1; step(); step(); rst = 1'b0;
    look(2'b00, 8'h00, "R10 requests cleared by reset");
    csr_read(1, 10'h000, "R10 status cleared by reset");

    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL leftover expectations: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule